// File: doc/BRIEF.md
# Indexed Extended Register Port

This block holds a bank of 8-bit extended configuration registers that sit behind one pair of I/O ports: an index port at byte address 0x1CE and a data port at 0x1CF. The host bus is presented in word form. Each access carries a word address, which is the byte address shifted right by one. It also carries two byte-lane enables, where lane 0 is the index port and lane 1 is the data port, plus write and read strobes and 16 bits of write data. Read data comes back one cycle after the read strobe, together with an acknowledge.

A register is written by a single 16-bit access that carries both bytes. The low byte is the register index and the high byte is the value. A register is read by first writing the index as a byte to the index port, then reading the data port.

The latched index is good for one data access only. After that it becomes invalid. A data-port byte written after an index byte is refused and still uses up the index. Selected bits of three registers drive the clock-select and clock-divider inputs of neighbouring logic.

Top module: `ext_reg_port`

## Requirements
- R1: After a synchronous reset, all of the following hold:
  - every implemented register reads 0x00;
  - the index is invalid;
  - rd_ack is 0;
  - div_sel and clk_sel are 0.
- R2: A write with both lanes enabled (io_be = 2'b11) to the port pair stores io_wdata[15:8] into the register selected by io_wdata[7:0].
- R3: A byte write of the index (io_be = 2'b01) followed by a data-port read (io_rd with io_be[1] = 1) returns that register on rd_data. rd_ack is high in the cycle after the read strobe.
- R4: The index is single-use. A second data-port read without a new index write returns 0xFF.
- R5: A data-port byte write (io_be = 2'b10) does not change any register and invalidates the latched index.
- R6: A data-port read with no valid index returns 0xFF and changes no register.
- R7: A two-lane write invalidates any index latched before it.
- R8: Only indices IDX_BASE to IDX_BASE+NUM_REGS-1 are implemented (0x80 to 0xBF by default). Writes to other indices have no effect, and reads of them return 0x00.
- R9: The exported fields are registered and follow register writes one cycle later:
  - div_sel equals bits 7:6 of register 0xB8;
  - clk_sel[1] equals bit 4 of register 0xBE;
  - clk_sel[0] equals bit 1 of register 0xB9.
- R10: Accesses whose word address is not the port pair (0x0E7), and reads without lane 1, are ignored. They store nothing, give no acknowledge, and leave the index untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_waddr | input | ADDR_W-1 | Word address (byte address >> 1) |
| io_be | input | 2 | Byte lanes: [0] index port, [1] data port |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data, low byte on lane 0 |
| rd_data | output | 8 | Registered read data |
| rd_ack | output | 1 | Read data valid, one cycle after the strobe |
| div_sel | output | 2 | Clock divider field |
| clk_sel | output | 2 | Clock select bits |

## Verification
The bench goes after the single-use index. A design that kept the index valid would return stale register contents on a repeated read instead of 0xFF. It tries the refused split write: a design that accepted the data byte would change the register, and one that did not consume the index would still return data on the next read. It also checks that a two-lane write drops a pending index, that indices and addresses outside the window change nothing, and that the divider and clock-select bits follow the correct register bits.

// File: rtl/ext_port_pkg.sv
package ext_port_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_IDX_WR,
    ACC_PAIR_WR,
    ACC_DATA_WR,
    ACC_DATA_RD
  } acc_e;

  localparam logic [7:0] NO_INDEX_READ = 8'hFF;
  localparam logic [7:0] UNIMPL_READ   = 8'h00;
endpackage

// File: rtl/ext_access_decode.sv
module ext_access_decode
  import ext_port_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PORT_BASE = 16'h01CE
) (
  input  logic [ADDR_W-2:0] io_waddr,
  input  logic [1:0]        io_be,
  input  logic              io_wr,
  input  logic              io_rd,
  output acc_e              acc
);
  localparam logic [ADDR_W-1:0] BASE_FULL = ADDR_W'(PORT_BASE);
  localparam logic [ADDR_W-2:0] PAIR_WADDR = BASE_FULL[ADDR_W-1:1];

  logic hit;
  assign hit = (io_waddr == PAIR_WADDR);

  always_comb begin
    acc = ACC_NONE;
    if (io_wr && hit) begin
      unique case (io_be)
        2'b11:   acc = ACC_PAIR_WR;
        2'b01:   acc = ACC_IDX_WR;
        2'b10:   acc = ACC_DATA_WR;
        default: acc = ACC_NONE;
      endcase
    end else if (io_rd && !io_wr && hit && io_be[1]) begin
      acc = ACC_DATA_RD;
    end
  end
endmodule

// File: rtl/ext_index_latch.sv
module ext_index_latch
  import ext_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  acc_e       acc,
  input  logic [7:0] new_index,
  output logic [7:0] index,
  output logic       valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      index <= '0;
      valid <= 1'b0;
    end else begin
      unique case (acc)
        ACC_IDX_WR: begin
          index <= new_index;
          valid <= 1'b1;
        end
        ACC_PAIR_WR, ACC_DATA_WR, ACC_DATA_RD: valid <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ext_reg_bank.sv
module ext_reg_bank
  import ext_port_pkg::*;
#(
  parameter int IDX_BASE  = 8'h80,
  parameter int NUM_REGS  = 64,
  parameter int DIV_IDX   = 8'hB8,
  parameter int CLKA_IDX  = 8'hB9,
  parameter int CLKB_IDX  = 8'hBE,
  parameter int DIV_LSB   = 6,
  parameter int CLKA_BIT  = 1,
  parameter int CLKB_BIT  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_val,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_val,
  output logic [1:0] div_sel,
  output logic [1:0] clk_sel
);
  localparam int OFF_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int DIV_OFF  = DIV_IDX - IDX_BASE;
  localparam int CLKA_OFF = CLKA_IDX - IDX_BASE;
  localparam int CLKB_OFF = CLKB_IDX - IDX_BASE;

  logic [7:0] regs [NUM_REGS];

  function automatic logic in_window(input logic [7:0] idx);
    return (int'(idx) >= IDX_BASE) && (int'(idx) < IDX_BASE + NUM_REGS);
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [7:0] idx);
    logic [7:0] rel;
    rel = idx - 8'(IDX_BASE);
    return rel[OFF_W-1:0];
  endfunction

  logic             wr_hit;
  logic [OFF_W-1:0] wr_off;
  assign wr_hit = wr_en && in_window(wr_idx);
  assign wr_off = offset_of(wr_idx);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (wr_hit && (wr_off == OFF_W'(g))) regs[g] <= wr_val;
    end
  end

  always_comb begin
    if (in_window(rd_idx)) rd_val = regs[offset_of(rd_idx)];
    else                   rd_val = UNIMPL_READ;
  end

  assign div_sel = regs[DIV_OFF][DIV_LSB+1:DIV_LSB];
  assign clk_sel = {regs[CLKB_OFF][CLKB_BIT], regs[CLKA_OFF][CLKA_BIT]};
endmodule

// File: rtl/ext_reg_port.sv
module ext_reg_port
  import ext_port_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PORT_BASE = 16'h01CE,
  parameter int IDX_BASE  = 8'h80,
  parameter int NUM_REGS  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-2:0] io_waddr,
  input  logic [1:0]        io_be,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [15:0]       io_wdata,
  output logic [7:0]        rd_data,
  output logic              rd_ack,
  output logic [1:0]        div_sel,
  output logic [1:0]        clk_sel
);
  acc_e       acc;
  logic [7:0] idx_q;
  logic       idx_valid;
  logic [7:0] bank_val;

  ext_access_decode #(.ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE)) u_dec (
    .io_waddr(io_waddr), .io_be(io_be), .io_wr(io_wr), .io_rd(io_rd), .acc(acc)
  );

  ext_index_latch u_idx (
    .clk(clk), .rst(rst), .acc(acc), .new_index(io_wdata[7:0]),
    .index(idx_q), .valid(idx_valid)
  );

  ext_reg_bank #(.IDX_BASE(IDX_BASE), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(acc == ACC_PAIR_WR), .wr_idx(io_wdata[7:0]), .wr_val(io_wdata[15:8]),
    .rd_idx(idx_q), .rd_val(bank_val),
    .div_sel(div_sel), .clk_sel(clk_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_ack  <= 1'b0;
    end else begin
      rd_ack <= (acc == ACC_DATA_RD);
      if (acc == ACC_DATA_RD) rd_data <= idx_valid ? bank_val : NO_INDEX_READ;
    end
  end
endmodule

// File: rtl/ext_reg_port_chk.sv
module ext_reg_port_chk #(
  parameter int ADDR_W    = 16,
  parameter int PORT_BASE = 16'h01CE
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-2:0] io_waddr,
  input logic [1:0]        io_be,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        rd_data,
  input logic              rd_ack,
  input logic [1:0]        div_sel,
  input logic [1:0]        clk_sel,
  input logic              idx_valid
);
  localparam logic [ADDR_W-1:0] BASE_FULL = ADDR_W'(PORT_BASE);
  logic at_pair, data_rd, pair_wr;
  assign at_pair = (io_waddr == BASE_FULL[ADDR_W-1:1]);
  assign data_rd = at_pair && io_rd && !io_wr && io_be[1];
  assign pair_wr = at_pair && io_wr && (io_be == 2'b11);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!rd_ack && div_sel == 2'b00 && clk_sel == 2'b00 && !idx_valid));

  p_read_ack_r3: assert property (@(posedge clk) disable iff (rst)
    data_rd |=> rd_ack);

  p_ack_has_cause_r10: assert property (@(posedge clk) disable iff (rst)
    !data_rd |=> !rd_ack);

  p_index_single_use_r4: assert property (@(posedge clk) disable iff (rst)
    data_rd |=> !idx_valid);

  p_no_index_ff_r6: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !idx_valid) |=> (rd_data == 8'hFF));

  p_pair_clears_index_r7: assert property (@(posedge clk) disable iff (rst)
    pair_wr |=> !idx_valid);

  p_exports_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !io_wr |=> ($stable(div_sel) && $stable(clk_sel)));
endmodule

bind ext_reg_port ext_reg_port_chk #(.ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE)) u_chk (
  .clk(clk), .rst(rst), .io_waddr(io_waddr), .io_be(io_be), .io_wr(io_wr),
  .io_rd(io_rd), .rd_data(rd_data), .rd_ack(rd_ack), .div_sel(div_sel),
  .clk_sel(clk_sel), .idx_valid(idx_valid)
);

// File: tb/ext_reg_port_bench.sv
`timescale 1ns/1ps
module ext_reg_port_bench;
  localparam logic [14:0] PAIR  = 15'h00E7;
  localparam logic [14:0] OTHER = 15'h01E7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] io_waddr = '0;
  logic [1:0]  io_be = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_ack;
  logic [1:0]  div_sel, clk_sel;

  int checks = 0, fails = 0, acks = 0, expected_acks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  ext_reg_port u_ext_reg_port (
    .clk(clk), .rst(rst), .io_waddr(io_waddr), .io_be(io_be), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .rd_data(rd_data), .rd_ack(rd_ack),
    .div_sel(div_sel), .clk_sel(clk_sel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected bytes as acknowledged reads appear
  always @(negedge clk) begin
    if (!rst && rd_ack) begin
      acks++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: unexpected rd_ack data 0x%0h expected none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  task automatic bus(input logic [14:0] a, input logic [1:0] be,
                     input logic w, input logic r, input logic [15:0] d);
    @(negedge clk);
    io_waddr = a; io_be = be; io_wr = w; io_rd = r; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0; io_be = '0;
  endtask

  task automatic wr16(input logic [7:0] idx, input logic [7:0] val);
    bus(PAIR, 2'b11, 1'b1, 1'b0, {val, idx});
  endtask

  task automatic wr_index(input logic [7:0] idx);
    bus(PAIR, 2'b01, 1'b1, 1'b0, {8'h00, idx});
  endtask

  task automatic rd_expect(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag); expected_acks++;
    bus(PAIR, 2'b10, 1'b0, 1'b1, 16'h0000);
  endtask

  task automatic read_reg(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    wr_index(idx);
    rd_expect(exp, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 rd_ack", rd_ack, 0);
    check("R1 div_sel", div_sel, 0);
    check("R1 clk_sel", clk_sel, 0);
    read_reg(8'h80, 8'h00, "R1 reg 0x80 zero");
    read_reg(8'hBF, 8'h00, "R1 reg 0xBF zero");

    // R2, R3: combined write then index-then-read
    wr16(8'h85, 8'h5A);
    read_reg(8'h85, 8'h5A, "R2 R3 readback 0x85");
    // R4: second read without new index
    rd_expect(8'hFF, "R4 reused index");

    // R5: split write refused and index consumed
    wr_index(8'h86);
    bus(PAIR, 2'b10, 1'b1, 1'b0, 16'h7700);
    rd_expect(8'hFF, "R5 index consumed by data byte write");
    read_reg(8'h86, 8'h00, "R5 register unchanged");

    // R6: read with invalid index has no side effects
    rd_expect(8'hFF, "R6 invalid index read");
    read_reg(8'h85, 8'h5A, "R6 register intact");

    // R7: combined write drops a pending index
    wr_index(8'h85);
    wr16(8'h90, 8'h33);
    rd_expect(8'hFF, "R7 pending index cleared");
    read_reg(8'h90, 8'h33, "R2 second register");

    // R8: indices outside the window
    wr16(8'h20, 8'hAB);
    read_reg(8'h20, 8'h00, "R8 low unimplemented");
    wr16(8'hC0, 8'h11);
    read_reg(8'hC0, 8'h00, "R8 high unimplemented");
    read_reg(8'h80, 8'h00, "R8 no alias into window");

    // R9: exported fields
    wr16(8'hB8, 8'hC0);
    check("R9 div_sel=3", div_sel, 3);
    wr16(8'hB9, 8'h02);
    check("R9 clk_sel=1", clk_sel, 1);
    wr16(8'hBE, 8'h10);
    check("R9 clk_sel=3", clk_sel, 3);
    wr16(8'hB8, 8'h7F);
    check("R9 div_sel=1", div_sel, 1);
    wr16(8'hB9, 8'hFD);
    check("R9 clk_sel=2", clk_sel, 2);
    read_reg(8'hB9, 8'hFD, "R9 readback 0xB9");

    // R10: misses and lane-0 reads are ignored
    bus(OTHER, 2'b11, 1'b1, 1'b0, {8'hEE, 8'h85});
    wr_index(8'h85);
    bus(OTHER, 2'b10, 1'b0, 1'b1, 16'h0000);
    bus(PAIR, 2'b01, 1'b0, 1'b1, 16'h0000);
    rd_expect(8'h5A, "R10 miss ignored, index kept");
    bus(OTHER, 2'b01, 1'b1, 1'b0, 16'h0090);
    rd_expect(8'hFF, "R10 index write elsewhere ignored");

    repeat (3) @(negedge clk);
    check("R10 ack count", acks, expected_acks);
    check("R3 queue drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule